// File: doc/BRIEF.md
# Two-Thread Shared Micro-Op Queue Allocator

This block is a pool of micro-op slots that two hardware threads fill and drain on their own. Each thread has an enqueue port with a stall output and a dequeue port that returns that thread's oldest entry. Slots come from one common free pool. A per-thread list of slot indices keeps each thread's entries in arrival order, whatever physical slots they occupy.

How much of the pool one thread may take is set by a static occupancy policy. The split policy gives each thread a fixed half. The capped policy lets a thread take any free slot up to a per-thread ceiling. The open policy puts no per-thread limit on a thread. Admission is decided in the same cycle as the request. When both threads are eligible and only one slot remains, a round-robin bit picks the winner. The policy input is only taken up while the whole queue is empty.

Top module: `dual_thread_uop_queue`

## Requirements
- R1: After reset both counts read 0, both empty flags read 1, the active mode reads 0 (split), no stall is raised without a request, and the round-robin bit favours thread 0.
- R2: In mode 0 (split) a thread holding DEPTH/2 entries is stalled on enqueue even when the other half is free.
- R3: In mode 1 (capped) a thread may hold at most CAP entries (default 12) and is stalled on enqueue when it holds CAP.
- R4: In modes 2 and 3 (open) one thread may fill all DEPTH slots.
- R5: When all DEPTH slots are held, any enqueue request is stalled, and the total held never exceeds DEPTH.
- R6: Each thread's dequeue returns that thread's entries in the order they were accepted, independent of the other thread.
- R7: When both threads are eligible and exactly one slot is free, the thread favoured by the round-robin bit wins (thread 0 first after reset) and the bit then toggles.
- R8: An enqueue and a dequeue by one thread in the same cycle are both accepted; the policy check uses the count before the dequeue.
- R9: The mode input is loaded into the active mode only in a cycle where both counts are zero; otherwise it has no effect.
- R10: Each count output equals that thread's held entries and moves by at most one per cycle; its empty flag is 1 exactly when the count is 0; a dequeue on an empty thread has no effect.
- R11: A stall output is 1 only while its thread requests an enqueue that is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| mode_i | input | 2 | Requested policy: 0 split, 1 capped, 2 or 3 open |
| t0_enq_vld | input | 1 | Thread 0 enqueue request |
| t0_enq_data | input | DATA_W | Thread 0 micro-op payload |
| t0_stall | output | 1 | Thread 0 enqueue refused this cycle |
| t0_deq | input | 1 | Thread 0 removes its oldest entry |
| t0_deq_data | output | DATA_W | Thread 0 oldest entry |
| t0_count | output | CNTW | Thread 0 held entries |
| t0_empty | output | 1 | Thread 0 holds nothing |
| t1_enq_vld | input | 1 | Thread 1 enqueue request |
| t1_enq_data | input | DATA_W | Thread 1 micro-op payload |
| t1_stall | output | 1 | Thread 1 enqueue refused this cycle |
| t1_deq | input | 1 | Thread 1 removes its oldest entry |
| t1_deq_data | output | DATA_W | Thread 1 oldest entry |
| t1_count | output | CNTW | Thread 1 held entries |
| t1_empty | output | 1 | Thread 1 holds nothing |
| cur_mode | output | 2 | Policy in force |

## Verification
The bound checker watches the policy ceilings, the total bound, forced stalls at a full pool or a full half, the freeze of the active mode while entries are held, the one-step count movement and the absence of stalls without a request on every cycle. Per-thread ordering of payloads, which thread wins a contested last slot and how the winner alternates, the pre-dequeue count rule, and ignored dequeues on an empty thread can only be shown by the bench's scenarios. The bench compares dequeued payloads against per-thread scoreboards and models admission separately.

// File: rtl/uq_pkg.sv
package uq_pkg;
  typedef enum logic [1:0] {
    QM_SPLIT    = 2'd0,
    QM_CAPPED   = 2'd1,
    QM_OPEN     = 2'd2,
    QM_OPEN_ALT = 2'd3
  } qmode_e;
endpackage

// File: rtl/uq_admit.sv
module uq_admit
  import uq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CAP   = 12,
  parameter int CNTW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  qmode_e          mode,
  input  logic [1:0]      req,
  input  logic [CNTW-1:0] cnt0,
  input  logic [CNTW-1:0] cnt1,
  output logic [1:0]      gnt
);
  localparam int HALF = DEPTH / 2;

  logic            rr_q, rr_d;
  logic [CNTW-1:0] limit;
  logic [CNTW:0]   held, free_n;
  logic            ok0, ok1, contend;

  always_comb begin
    case (mode)
      QM_SPLIT:  limit = CNTW'(HALF);
      QM_CAPPED: limit = CNTW'(CAP);
      default:   limit = CNTW'(DEPTH);
    endcase
    held    = {1'b0, cnt0} + {1'b0, cnt1};
    free_n  = (CNTW+1)'(DEPTH) - held;
    ok0     = req[0] && (cnt0 < limit);
    ok1     = req[1] && (cnt1 < limit);
    contend = ok0 && ok1 && (free_n == (CNTW+1)'(1));
    if (free_n == '0) begin
      gnt = 2'b00;
    end else if (contend) begin
      gnt = rr_q ? 2'b10 : 2'b01;
    end else begin
      gnt = {ok1, ok0};
    end
    rr_d = rr_q ^ contend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= 1'b0;
    else        rr_q <= rr_d;
  end
endmodule

// File: rtl/uq_free_pool.sv
module uq_free_pool #(
  parameter int DEPTH = 16,
  parameter int IDXW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_a,
  input  logic            take_b,
  input  logic            rel0,
  input  logic [IDXW-1:0] rel_idx0,
  input  logic            rel1,
  input  logic [IDXW-1:0] rel_idx1,
  output logic [IDXW-1:0] idx_a,
  output logic [IDXW-1:0] idx_b
);
  logic [DEPTH-1:0] free_q, free_d, rest, used, back;

  always_comb begin
    idx_a = '0;
    for (int i = DEPTH - 1; i >= 0; i--) if (free_q[i]) idx_a = IDXW'(i);
    rest        = free_q;
    rest[idx_a] = 1'b0;
    idx_b = '0;
    for (int i = DEPTH - 1; i >= 0; i--) if (rest[i]) idx_b = IDXW'(i);
    used = '0;
    if (take_a) used[idx_a] = 1'b1;
    if (take_b) used[idx_b] = 1'b1;
    back = '0;
    if (rel0) back[rel_idx0] = 1'b1;
    if (rel1) back[rel_idx1] = 1'b1;
    free_d = (free_q & ~used) | back;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= free_d;
  end
endmodule

// File: rtl/uq_order_fifo.sv
module uq_order_fifo #(
  parameter int DEPTH = 16,
  parameter int IDXW  = 4,
  parameter int CNTW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [IDXW-1:0] push_idx,
  input  logic            pop,
  output logic [IDXW-1:0] head_idx,
  output logic [CNTW-1:0] count
);
  logic [IDXW-1:0] ring [DEPTH];
  logic [IDXW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNTW-1:0] cnt_q, cnt_d;

  function automatic logic [IDXW-1:0] bump(input logic [IDXW-1:0] p);
    return (p == IDXW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = push ? bump(wp_q) : wp_q;
    rp_d  = pop  ? bump(rp_q) : rp_q;
    cnt_d = cnt_q + CNTW'(push) - CNTW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) ring[wp_q] <= push_idx;
  end

  assign head_idx = ring[rp_q];
  assign count    = cnt_q;
endmodule

// File: rtl/dual_thread_uop_queue.sv
module dual_thread_uop_queue
  import uq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CAP    = 12,
  parameter int DATA_W = 8,
  localparam int IDXW  = $clog2(DEPTH),
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              t0_enq_vld,
  input  logic [DATA_W-1:0] t0_enq_data,
  output logic              t0_stall,
  input  logic              t0_deq,
  output logic [DATA_W-1:0] t0_deq_data,
  output logic [CNTW-1:0]   t0_count,
  output logic              t0_empty,
  input  logic              t1_enq_vld,
  input  logic [DATA_W-1:0] t1_enq_data,
  output logic              t1_stall,
  input  logic              t1_deq,
  output logic [DATA_W-1:0] t1_deq_data,
  output logic [CNTW-1:0]   t1_count,
  output logic              t1_empty,
  output logic [1:0]        cur_mode
);
  qmode_e            mode_q, mode_d;
  logic [1:0]        req, gnt, pop, deq_r;
  logic [CNTW-1:0]   cnt  [2];
  logic [IDXW-1:0]   slot [2];
  logic [IDXW-1:0]   head [2];
  logic [DATA_W-1:0] wdat [2];
  logic [IDXW-1:0]   idx_a, idx_b;
  logic [DATA_W-1:0] store [DEPTH];

  assign req     = {t1_enq_vld, t0_enq_vld};
  assign deq_r   = {t1_deq, t0_deq};
  assign wdat[0] = t0_enq_data;
  assign wdat[1] = t1_enq_data;

  always_comb begin
    mode_d = ((cnt[0] == '0) && (cnt[1] == '0)) ? qmode_e'(mode_i) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= QM_SPLIT;
    else        mode_q <= mode_d;
  end

  uq_admit #(.DEPTH(DEPTH), .CAP(CAP), .CNTW(CNTW)) u_admit (
    .clk (clk), .rst_n (rst_n), .mode (mode_q), .req (req),
    .cnt0 (cnt[0]), .cnt1 (cnt[1]), .gnt (gnt)
  );

  uq_free_pool #(.DEPTH(DEPTH), .IDXW(IDXW)) u_pool (
    .clk (clk), .rst_n (rst_n),
    .take_a (gnt[0] | gnt[1]), .take_b (gnt[0] & gnt[1]),
    .rel0 (pop[0]), .rel_idx0 (head[0]),
    .rel1 (pop[1]), .rel_idx1 (head[1]),
    .idx_a (idx_a), .idx_b (idx_b)
  );

  assign slot[0] = idx_a;
  assign slot[1] = gnt[0] ? idx_b : idx_a;

  for (genvar t = 0; t < 2; t++) begin : g_thr
    assign pop[t] = deq_r[t] && (cnt[t] != '0);

    uq_order_fifo #(.DEPTH(DEPTH), .IDXW(IDXW), .CNTW(CNTW)) u_order (
      .clk (clk), .rst_n (rst_n),
      .push (gnt[t]), .push_idx (slot[t]),
      .pop (pop[t]), .head_idx (head[t]), .count (cnt[t])
    );

    always_ff @(posedge clk) begin
      if (gnt[t]) store[slot[t]] <= wdat[t];
    end
  end

  assign t0_stall    = req[0] & ~gnt[0];
  assign t1_stall    = req[1] & ~gnt[1];
  assign t0_deq_data = store[head[0]];
  assign t1_deq_data = store[head[1]];
  assign t0_count    = cnt[0];
  assign t1_count    = cnt[1];
  assign t0_empty    = (cnt[0] == '0);
  assign t1_empty    = (cnt[1] == '0);
  assign cur_mode    = mode_q;
endmodule

// File: rtl/uq_checker.sv
module uq_checker #(
  parameter int DEPTH = 16,
  parameter int CAP   = 12,
  parameter int CNTW  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cur_mode,
  input logic            t0_enq_vld,
  input logic            t1_enq_vld,
  input logic            t0_stall,
  input logic            t1_stall,
  input logic [CNTW-1:0] t0_count,
  input logic [CNTW-1:0] t1_count
);
  localparam int HALF = DEPTH / 2;
  int held;
  assign held = int'(t0_count) + int'(t1_count);

  p_split_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'd0) |-> (int'(t0_count) <= HALF && int'(t1_count) <= HALF));

  p_split_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'd0 && int'(t0_count) == HALF && t0_enq_vld) |-> t0_stall);

  p_capped_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'd1) |-> (int'(t0_count) <= CAP && int'(t1_count) <= CAP));

  p_total_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    held <= DEPTH);

  p_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (held == DEPTH && (t0_enq_vld || t1_enq_vld)) |->
      ((t0_stall || !t0_enq_vld) && (t1_stall || !t1_enq_vld)));

  p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (held != 0) |=> $stable(cur_mode));

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (int'(t0_count) <= int'($past(t0_count)) + 1 &&
              int'(t1_count) <= int'($past(t1_count)) + 1));

  p_idle_no_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!t0_enq_vld |-> !t0_stall) and (!t1_enq_vld |-> !t1_stall));
endmodule

bind dual_thread_uop_queue uq_checker #(.DEPTH(DEPTH), .CAP(CAP), .CNTW(CNTW)) u_chk (
  .clk (clk), .rst_n (rst_n), .cur_mode (cur_mode),
  .t0_enq_vld (t0_enq_vld), .t1_enq_vld (t1_enq_vld),
  .t0_stall (t0_stall), .t1_stall (t1_stall),
  .t0_count (t0_count), .t1_count (t1_count)
);

// File: tb/tb_dual_thread_uop_queue.sv
module tb_dual_thread_uop_queue;
  localparam int DEPTH = 16;
  localparam int CAP   = 12;
  localparam int DW    = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk, rst_n;
  logic [1:0] mode_i;
  logic t0_enq_vld, t1_enq_vld, t0_deq, t1_deq;
  logic [DW-1:0] t0_enq_data, t1_enq_data, t0_deq_data, t1_deq_data;
  logic t0_stall, t1_stall, t0_empty, t1_empty;
  logic [CW-1:0] t0_count, t1_count;
  logic [1:0] cur_mode;

  dual_thread_uop_queue #(.DEPTH(DEPTH), .CAP(CAP), .DATA_W(DW)) dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int m_cnt [2];
  int m_mode = 0;
  bit m_rr = 0;
  int seq = 1;
  int sb [2][$];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk(int'(t0_count) == m_cnt[0], tag, "t0_count", int'(t0_count), m_cnt[0]);
    chk(int'(t1_count) == m_cnt[1], tag, "t1_count", int'(t1_count), m_cnt[1]);
    chk(t0_empty == (m_cnt[0] == 0), tag, "t0_empty", int'(t0_empty), int'(m_cnt[0] == 0));
    chk(t1_empty == (m_cnt[1] == 0), tag, "t1_empty", int'(t1_empty), int'(m_cnt[1] == 0));
    chk(int'(cur_mode) == m_mode, tag, "cur_mode", int'(cur_mode), m_mode);
  endtask

  // one cycle: drive, predict admission, compare stalls and dequeued payloads
  task automatic step(input bit e0, input bit e1, input bit q0, input bit q1, input string tag);
    int lim, free_n;
    bit ok0, ok1, g0, g1;
    bit p0, p1;
    logic [DW-1:0] d0, d1;
    @(negedge clk);
    d0 = DW'(seq); d1 = DW'(seq + 1); seq += 2;
    t0_enq_vld = e0; t1_enq_vld = e1; t0_deq = q0; t1_deq = q1;
    t0_enq_data = d0; t1_enq_data = d1;
    #1;
    lim = (m_mode == 0) ? DEPTH / 2 : (m_mode == 1) ? CAP : DEPTH;
    free_n = DEPTH - m_cnt[0] - m_cnt[1];
    ok0 = e0 && m_cnt[0] < lim;
    ok1 = e1 && m_cnt[1] < lim;
    if (free_n == 0) begin g0 = 0; g1 = 0; end
    else if (ok0 && ok1 && free_n == 1) begin
      g0 = !m_rr; g1 = m_rr; m_rr = !m_rr;
    end else begin g0 = ok0; g1 = ok1; end
    chk(t0_stall == (e0 && !g0), tag, "t0_stall", int'(t0_stall), int'(e0 && !g0));
    chk(t1_stall == (e1 && !g1), tag, "t1_stall", int'(t1_stall), int'(e1 && !g1));
    p0 = q0 && m_cnt[0] > 0;
    p1 = q1 && m_cnt[1] > 0;
    if (p0) begin
      int exp0 = sb[0].pop_front();
      chk(int'(t0_deq_data) == exp0, tag, "t0_deq_data", int'(t0_deq_data), exp0);
    end
    if (p1) begin
      int exp1 = sb[1].pop_front();
      chk(int'(t1_deq_data) == exp1, tag, "t1_deq_data", int'(t1_deq_data), exp1);
    end
    if (g0) sb[0].push_back(int'(d0));
    if (g1) sb[1].push_back(int'(d1));
    if (m_cnt[0] == 0 && m_cnt[1] == 0) m_mode = int'(mode_i);
    m_cnt[0] += int'(g0) - int'(p0);
    m_cnt[1] += int'(g1) - int'(p1);
    @(posedge clk);
    #1;
    check_state(tag);
    t0_enq_vld = 0; t1_enq_vld = 0; t0_deq = 0; t1_deq = 0;
  endtask

  task automatic drain(input string tag);
    while (m_cnt[0] > 0 || m_cnt[1] > 0) step(0, 0, 1, 1, tag);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    m_cnt[0] = 0; m_cnt[1] = 0;
    rst_n = 0; mode_i = 2'd0;
    t0_enq_vld = 0; t1_enq_vld = 0; t0_deq = 0; t1_deq = 0;
    t0_enq_data = '0; t1_enq_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check_state("R1");
    chk(!t0_stall && !t1_stall, "R1", "stall idle", int'(t0_stall | t1_stall), 0);
    step(0, 0, 0, 0, "R11");

    // split policy: thread 0 stops at half, thread 1 still admitted
    for (int i = 0; i < 10; i++) step(1, 0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R2");
    step(1, 1, 0, 0, "R6");
    // mode change while holding entries is ignored
    mode_i = 2'd1;
    step(0, 0, 0, 0, "R9");
    step(0, 1, 1, 0, "R9");
    drain("R6");
    step(0, 0, 0, 0, "R9");
    step(0, 0, 1, 0, "R10");

    // capped policy
    for (int i = 0; i < 14; i++) step(1, 0, 0, 0, "R3");
    for (int i = 0; i < 6; i++) step(0, 1, 0, 0, "R5");
    step(1, 1, 0, 0, "R5");
    step(0, 0, 1, 0, "R7");
    step(1, 1, 0, 0, "R7");
    step(0, 0, 1, 0, "R7");
    step(1, 1, 0, 0, "R7");
    step(1, 0, 1, 0, "R8");
    step(1, 0, 1, 0, "R8");
    step(0, 1, 0, 1, "R8");
    drain("R6");

    // open policy
    mode_i = 2'd2;
    step(0, 0, 0, 0, "R9");
    for (int i = 0; i < 17; i++) step(1, 0, 0, 0, "R4");
    step(1, 1, 0, 0, "R5");
    for (int i = 0; i < 5; i++) step(0, 1, 1, 0, "R6");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1, "R6");
    drain("R6");

    // alternate open encoding, interleaved pushes
    mode_i = 2'd3;
    step(0, 0, 0, 0, "R9");
    for (int i = 0; i < 9; i++) step(1, 1, 0, 0, "R4");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, "R10");
    step(1, 1, 0, 0, "R7");
    drain("R6");
    step(0, 0, 1, 1, "R10");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule